// File: doc/BRIEF.md
# Multi-Port Warp Issue Scheduler

This block decides, every clock cycle, which resident warps of one multiprocessor slice send an instruction down each of several parallel issue ports. It keeps a fixed pool of warp slots. Each slot holds a resident flag and a stall countdown. A warp is eligible when it is resident and its countdown is zero. Changing from one warp to another costs nothing: a port may grant a different warp on every cycle, because the state of each warp is already held in the slot.

Warps enter through an admit request. The block answers in the same cycle with the lowest free slot, or refuses the request when every slot is occupied. A warp leaves through a retire request. When a warp starts a long memory access, the surrounding pipeline sends a stall request with a latency value, and the warp drops out of arbitration for that many cycles. Each port arbitrates round-robin from just after its own last grant. Ports are served in index order, so a warp taken by a lower port is not offered to a higher one. A free-running counter adds up the idle port-cycles, so the hiding of latency can be measured.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held and just after it, no port issues, `idle_count` is 0 and `admit_ok` is 0 when no admit is requested.
- R2: An admit request with a free slot sets `admit_ok` in the same cycle, and `admit_slot` is the lowest-numbered free slot. That warp is resident and eligible from the next cycle.
- R3: When all `NUM_WARPS` slots (64 by default) are resident, `admit_ok` is 0 and no slot changes.
- R4: A retire request clears the slot at the next clock edge. An admit in that same cycle is still refused when the pool was full. On the following cycle the freed slot is offered.
- R5: A stall request of latency L>0 on a resident warp in cycle t keeps that warp from being granted in cycles t+1..t+L, and it is eligible again in cycle t+L+1. A stall request on a non-resident slot has no effect, and a latency of 0 causes no stall.
- R6: In each cycle the number of ports that grant equals min(`NUM_PORTS`, number of eligible warps), with no penalty cycle between different warps.
- R7: No warp is granted on two ports in the same cycle.
- R8: Port p grants the first eligible warp not taken by ports 0..p-1, searching upward from one above port p's previous grant and wrapping modulo `NUM_WARPS`. After reset each port behaves as if its previous grant were slot `NUM_WARPS-1`.
- R9: `idle_count` grows at each clock edge by the number of ports that did not grant in that cycle, and wraps at 2^`IDLE_W`.
- R10: With one resident warp stalled, every port stays idle for the whole stall window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| admit_req | input | 1 | Request to admit a new warp |
| admit_ok | output | 1 | Admit accepted this cycle |
| admit_slot | output | $clog2(NUM_WARPS) | Slot given to the admitted warp |
| retire_valid | input | 1 | Retire the warp in `retire_id` |
| retire_id | input | $clog2(NUM_WARPS) | Slot to free |
| stall_valid | input | 1 | Apply a memory stall |
| stall_id | input | $clog2(NUM_WARPS) | Slot to stall |
| stall_lat | input | LAT_W | Stall length in cycles |
| issue_valid | output | NUM_PORTS | Per-port grant flag |
| issue_warp | output | NUM_PORTS*$clog2(NUM_WARPS) | Per-port granted slot; port p at bits [p*W +: W] |
| idle_count | output | IDLE_W | Running count of idle port-cycles |

## Verification
The bench goes after the full pool: a design that checked the ceiling wrongly would hand out a slot that is already resident, or it would accept the admit that arrives in the same cycle as a retire. It measures a single stalled warp exactly to the cycle, so a stall window off by one shows up as an early or late grant and a wrong idle total. Long random runs with many stalls and two ports expose a duplicate grant, a port that sits idle while a ready warp is waiting, or a pointer that does not resume after its own last grant.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Next candidate index in a circular search of n slots.
  function automatic int unsigned wrap_next(int unsigned base, int unsigned step,
                                            int unsigned n);
    return (base + step) % n;
  endfunction

  // Ports left without a grant in one cycle.
  function automatic int unsigned idle_ports(int unsigned ports, int unsigned granted);
    return ports - granted;
  endfunction

endpackage

// File: rtl/wsched_slot.sv
module wsched_slot #(
  parameter int LAT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             admit_hit,
  input  logic             retire_hit,
  input  logic             stall_hit,
  input  logic [LAT_W-1:0] stall_lat,
  output logic             resident,
  output logic             eligible
);
  logic [LAT_W-1:0] cnt_q;
  logic             res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= 1'b0;
      cnt_q <= '0;
    end else if (admit_hit) begin
      res_q <= 1'b1;
      cnt_q <= '0;
    end else if (retire_hit) begin
      res_q <= 1'b0;
      cnt_q <= '0;
    end else if (stall_hit && res_q) begin
      cnt_q <= stall_lat;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign resident = res_q;
  assign eligible = res_q && (cnt_q == '0);

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q && stall_hit && !retire_hit && !admit_hit && stall_lat != '0) |=> !eligible); // R5
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q && cnt_q == LAT_W'(1) && !stall_hit && !retire_hit) |=> eligible); // R5
  AST_IDLE_SLOT_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_q && !admit_hit) |=> !resident); // R5
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_hit && !admit_hit) |=> !resident); // R4
endmodule

// File: rtl/wsched_arbiter.sv
module wsched_arbiter #(
  parameter int NUM_WARPS = 64,
  parameter int NUM_PORTS = 2,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WARPS-1:0]       elig,
  output logic [NUM_PORTS-1:0]       grant_valid,
  output logic [NUM_PORTS*WID_W-1:0] grant_id
);
  import wsched_pkg::*;

  // stage[p] holds the warps still on offer to port p.
  logic [NUM_WARPS-1:0] stage [NUM_PORTS+1];
  logic [NUM_WARPS-1:0] grant_or;

  assign stage[0] = elig;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [WID_W-1:0] last_q;
    logic [WID_W-1:0] pick;
    logic             found;

    always_comb begin
      int unsigned j;
      found = 1'b0;
      pick  = '0;
      for (int unsigned k = 1; k <= 32'(NUM_WARPS); k++) begin
        j = wrap_next(32'(last_q), k, 32'(NUM_WARPS));
        if (!found && stage[p][j]) begin
          found = 1'b1;
          pick  = WID_W'(j);
        end
      end
    end

    assign stage[p+1] = found ? (stage[p] & ~(NUM_WARPS'(1) << pick)) : stage[p];
    assign grant_valid[p] = found;
    assign grant_id[p*WID_W +: WID_W] = pick;

    always_ff @(posedge clk) begin
      if (!rst_n)     last_q <= WID_W'(NUM_WARPS - 1);
      else if (found) last_q <= pick;
    end

    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> elig[pick]); // R6
    AST_NO_WASTED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (stage[p] == '0)); // R6
  end

  always_comb begin
    grant_or = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (grant_valid[p]) grant_or = grant_or | (NUM_WARPS'(1) << grant_id[p*WID_W +: WID_W]);
  end

  AST_NO_DUP_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_or) == $countones(grant_valid)); // R7
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 64,
  parameter int NUM_PORTS = 2,
  parameter int LAT_W     = 9,
  parameter int IDLE_W    = 32,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       admit_req,
  output logic                       admit_ok,
  output logic [WID_W-1:0]           admit_slot,
  input  logic                       retire_valid,
  input  logic [WID_W-1:0]           retire_id,
  input  logic                       stall_valid,
  input  logic [WID_W-1:0]           stall_id,
  input  logic [LAT_W-1:0]           stall_lat,
  output logic [NUM_PORTS-1:0]       issue_valid,
  output logic [NUM_PORTS*WID_W-1:0] issue_warp,
  output logic [IDLE_W-1:0]          idle_count
);
  import wsched_pkg::*;

  function automatic logic [WID_W-1:0] lowest_free(logic [NUM_WARPS-1:0] freem);
    logic [WID_W-1:0] r;
    r = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--)
      if (freem[i]) r = WID_W'(i);
    return r;
  endfunction

  logic [NUM_WARPS-1:0] resident, eligible;
  logic [NUM_WARPS-1:0] admit_hit, retire_hit, stall_hit;
  logic [NUM_WARPS-1:0] free_mask;
  logic [IDLE_W-1:0]    idle_step;

  assign free_mask  = ~resident;
  assign admit_ok   = admit_req && (free_mask != '0);
  assign admit_slot = lowest_free(free_mask);
  assign admit_hit  = admit_ok ? (NUM_WARPS'(1) << admit_slot) : '0;
  assign retire_hit = retire_valid ? (NUM_WARPS'(1) << retire_id) : '0;
  assign stall_hit  = stall_valid ? (NUM_WARPS'(1) << stall_id) : '0;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    wsched_slot #(.LAT_W(LAT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .admit_hit (admit_hit[w]),
      .retire_hit(retire_hit[w]),
      .stall_hit (stall_hit[w]),
      .stall_lat (stall_lat),
      .resident  (resident[w]),
      .eligible  (eligible[w])
    );
  end

  wsched_arbiter #(.NUM_WARPS(NUM_WARPS), .NUM_PORTS(NUM_PORTS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig       (eligible),
    .grant_valid(issue_valid),
    .grant_id   (issue_warp)
  );

  assign idle_step = IDLE_W'(idle_ports(32'(NUM_PORTS), 32'($countones(issue_valid))));

  always_ff @(posedge clk) begin
    if (!rst_n) idle_count <= '0;
    else        idle_count <= idle_count + idle_step;
  end

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (admit_req && (&resident)) |-> !admit_ok); // R3
  AST_ADMIT_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    admit_ok |-> !resident[admit_slot]); // R2
  AST_ADMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    admit_ok |=> resident[$past(admit_slot)]); // R2
  AST_IDLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (IDLE_W'(idle_count - $past(idle_count)) <= IDLE_W'(NUM_PORTS))); // R9
endmodule

// File: tb/warp_issue_sched_test.sv
`timescale 1ns/1ps
module warp_issue_sched_test;
  localparam int NW = 64;
  localparam int NP = 2;
  localparam int LW = 9;
  localparam int IW = 32;
  localparam int W  = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          admit_req, admit_ok;
  logic [W-1:0]  admit_slot;
  logic          retire_valid, stall_valid;
  logic [W-1:0]  retire_id, stall_id;
  logic [LW-1:0] stall_lat;
  logic [NP-1:0] issue_valid;
  logic [NP*W-1:0] issue_warp;
  logic [IW-1:0] idle_count;

  always #2.5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_PORTS(NP), .LAT_W(LW), .IDLE_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .admit_req(admit_req), .admit_ok(admit_ok),
    .admit_slot(admit_slot), .retire_valid(retire_valid), .retire_id(retire_id),
    .stall_valid(stall_valid), .stall_id(stall_id), .stall_lat(stall_lat),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .idle_count(idle_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  bit          m_res [NW];
  int          m_cnt [NW];
  int          m_last[NP];
  int unsigned m_idle;
  int          obs_nvalid;
  bit          obs_ok;
  int          obs_slot;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < NW; i++) if (m_res[i]) n++;
    return n;
  endfunction

  task automatic cycle(bit a, bit rv, int rid, bit sv, int sid, int slat);
    bit av[NW];
    bit gv[NP];
    int gid[NP];
    bit exp_ok;
    int exp_slot;
    int ng;
    @(negedge clk);
    rst_n        = 1'b1;
    admit_req    = a;
    retire_valid = rv;
    retire_id    = W'(rid);
    stall_valid  = sv;
    stall_id     = W'(sid);
    stall_lat    = LW'(slat);
    #1;
    for (int i = 0; i < NW; i++) av[i] = m_res[i] && (m_cnt[i] == 0);
    ng = 0;
    for (int p = 0; p < NP; p++) begin
      gv[p] = 1'b0; gid[p] = 0;
      for (int k = 1; k <= NW; k++) begin
        int j = (m_last[p] + k) % NW;
        if (!gv[p] && av[j]) begin gv[p] = 1'b1; gid[p] = j; end
      end
      if (gv[p]) begin av[gid[p]] = 1'b0; ng++; end
      check(issue_valid[p] == gv[p], "R6", "port grant flag", issue_valid[p], gv[p]);
      if (gv[p])
        check(int'(issue_warp[p*W +: W]) == gid[p], "R8", "round-robin pick",
              issue_warp[p*W +: W], gid[p]);
    end
    if (issue_valid[0] && issue_valid[1])
      check(issue_warp[0 +: W] != issue_warp[W +: W], "R7", "distinct warps",
            issue_warp[W +: W], -1);
    exp_ok = 1'b0; exp_slot = 0;
    if (a)
      for (int i = NW - 1; i >= 0; i--) if (!m_res[i]) begin exp_ok = 1'b1; exp_slot = i; end
    check(admit_ok == exp_ok, "R2", "admit accept", admit_ok, exp_ok);
    if (exp_ok) check(int'(admit_slot) == exp_slot, "R2", "admit slot", admit_slot, exp_slot);
    check(idle_count == m_idle, "R9", "idle count", idle_count, m_idle);
    obs_nvalid = $countones(issue_valid);
    obs_ok     = admit_ok;
    obs_slot   = int'(admit_slot);
    // advance reference to the next cycle
    m_idle += NP - ng;
    for (int p = 0; p < NP; p++) if (gv[p]) m_last[p] = gid[p];
    for (int i = 0; i < NW; i++) begin
      if (exp_ok && i == exp_slot) begin m_res[i] = 1'b1; m_cnt[i] = 0; end
      else if (rv && i == rid)    begin m_res[i] = 1'b0; m_cnt[i] = 0; end
      else if (sv && i == sid && m_res[i]) m_cnt[i] = slat;
      else if (m_cnt[i] > 0) m_cnt[i]--;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; admit_req = 1'b0; retire_valid = 1'b0; stall_valid = 1'b0;
    retire_id = '0; stall_id = '0; stall_lat = '0;
    for (int i = 0; i < NW; i++) begin m_res[i] = 1'b0; m_cnt[i] = 0; end
    for (int p = 0; p < NP; p++) m_last[p] = NW - 1;
    m_idle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(issue_valid == '0, "R1", "issue in reset", issue_valid, 0);
    check(idle_count == '0, "R1", "idle in reset", idle_count, 0);
    check(admit_ok == 1'b0, "R1", "admit in reset", admit_ok, 0);

    // Single warp: admit, then stall for 40 cycles
    cycle(1, 0, 0, 0, 0, 0);
    check(obs_ok == 1'b1 && obs_slot == 0, "R2", "first admit slot", obs_slot, 0);
    cycle(0, 0, 0, 1, 0, 40);
    check(obs_nvalid == 1, "R6", "lone warp issues", obs_nvalid, 1);
    for (int c = 0; c < 40; c++) begin
      cycle(0, 0, 0, 0, 0, 0);
      check(obs_nvalid == 0, "R10", "ports idle during stall", obs_nvalid, 0);
    end
    cycle(0, 0, 0, 0, 0, 0);
    check(obs_nvalid == 1, "R5", "warp back after stall", obs_nvalid, 1);
    // stall on a free slot is ignored
    cycle(0, 0, 0, 1, 7, 30);
    cycle(1, 0, 0, 0, 0, 0);
    check(obs_slot == 1, "R2", "next free slot", obs_slot, 1);
    cycle(0, 0, 0, 0, 0, 0);
    check(obs_nvalid == 2, "R6", "two warps two ports", obs_nvalid, 2);

    // Several warps, round robin with a few stalls
    for (int i = 0; i < 4; i++) cycle(1, 0, 0, 0, 0, 0);
    for (int c = 0; c < 30; c++) cycle(0, 0, 0, (c % 5) == 0, c % 6, 3);

    // Fill the pool and hit the ceiling
    while (model_count() < NW) cycle(1, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0);
    check(obs_ok == 1'b0, "R3", "admit refused when full", obs_ok, 0);
    cycle(1, 1, 10, 0, 0, 0);
    check(obs_ok == 1'b0, "R4", "admit refused in retire cycle", obs_ok, 0);
    cycle(1, 0, 0, 0, 0, 0);
    check(obs_ok == 1'b1 && obs_slot == 10, "R4", "freed slot reused", obs_slot, 10);

    // Random mix
    for (int c = 0; c < 3000; c++)
      cycle(($urandom % 4) == 0, ($urandom % 5) == 0, int'($urandom % NW),
            ($urandom % 2) == 0, int'($urandom % NW), int'($urandom_range(0, 300)));
    for (int c = 0; c < 320; c++) cycle(0, 0, 0, 0, 0, 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule